// File: doc/BRIEF.md
# Line-doubled VGA scanout sequencer

This block produces horizontal sync, vertical sync and an 8-bit colour stream from a frame buffer that holds one byte per pixel. A line timer counts pixel clocks across a fixed line period. At every line boundary a vertical sequencer advances through four phases: back porch, visible area, front porch and vertical sync. On every visible line it starts a fixed-length burst of pixel reads through a synchronous memory port with one cycle of latency. The returned bytes appear on the colour output one pixel clock after the line starts.

Each frame-buffer row is shown on two consecutive scan lines. The row address is taken from the frame base input when the visible area begins. It steps forward by one row length only before a line whose index is even. It folds back to the base when it would pass the end of the screen buffer. Outside each burst the colour output is held at zero. Both vertical sync edges fall on line boundaries, one line after the phase change that causes them.

Top module: `vga_scan_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it, the block is in back porch with line index 0 and horizontal position 0. hsync_n and vsync_n are 1, pix is 0 and mem_rd_en is 0.
- R2: Horizontal position h counts 0 to LINE_PERIOD-1 and then wraps. hsync_n is 0 exactly when HS_START <= h < HS_END. This window lies after the last pixel of the burst.
- R3: The phase changes only at a line boundary, always in the order back porch, visible, front porch, vsync, back porch. Line indices below VIS_START are back porch. VIS_START to VFP_START-1 are visible. VFP_START to VSYNC_START-1 are front porch. VSYNC_START to VSYNC_END-1 are vsync.
- R4: The line index returns to 0 after line VSYNC_END-1. Consecutive falling edges of vsync_n are therefore VSYNC_END*LINE_PERIOD clocks apart.
- R5: On a visible line, mem_rd_en is 1 for h = 0 to LINE_LEN-1 and mem_addr = row + h. The byte read at h appears on pix at h+1, so pixel k is shown at h = k+1.
- R6: On the first visible line, row equals the value of frame_base captured at that line boundary.
- R7: Row advances by LINE_LEN at a boundary into a visible line only when that line's index is even. Otherwise it holds, so each row is shown on two scan lines.
- R8: If the advanced row would be at or beyond captured base + SCREEN_SIZE, row becomes the captured base instead.
- R9: pix is 0 at every clock other than h = 1 to LINE_LEN of a visible line.
- R10: vsync_n is 0 on lines VSYNC_START+1 to VSYNC_END-1 and on line 0 of the following frame. Both of its edges occur at h = 0.
- R11: mem_rd_en is 0 on every line outside the visible phase, including the line where the front porch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_base | input | ADDR_W | Start address of the frame buffer, captured when the visible area begins |
| mem_rd_en | output | 1 | Pixel memory read strobe |
| mem_addr | output | ADDR_W | Pixel memory read address |
| mem_rdata | input | PIX_W | Pixel memory data, valid one clock after the read |
| pix | output | PIX_W | Colour output, zero outside the active pixels |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench keeps its own line and position model, advanced on the same rising edge as the design. It compares every output at the falling edge that follows. Read strobe, address and both syncs are due in the same cycle as the position they belong to. Phase, row and vsync changes take effect at h = 0, one edge after h = LINE_PERIOD-1. The byte requested at position h is due on pix at h+1, because the memory adds one register. The bench therefore compares pix against the address its model issued one position earlier. The frame period is measured between vsync falling edges in whole clocks.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
   typedef enum logic [1:0] {
      VP_BACK  = 2'd0,
      VP_SHOW  = 2'd1,
      VP_FRONT = 2'd2,
      VP_SYNC  = 2'd3
   } vphase_t;
endpackage

// File: rtl/vga_line_timer.sv
module vga_line_timer #(
   parameter int LINE_PERIOD = 200,
   parameter int HS_START    = 168,
   parameter int HS_END      = 184,
   parameter int HC_W        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [HC_W-1:0] hc,
   output logic            line_end,
   output logic            hsync_n
);
   localparam logic [HC_W-1:0] LAST = HC_W'(LINE_PERIOD - 1);
   localparam logic [HC_W-1:0] HS_A = HC_W'(HS_START);
   localparam logic [HC_W-1:0] HS_B = HC_W'(HS_END);

   assign line_end = (hc == LAST);
   assign hsync_n  = !((hc >= HS_A) && (hc < HS_B));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hc <= '0;
      else if (line_end) hc <= '0;
      else               hc <= hc + 1'b1;
   end

   // R2: the position never leaves the line period
   p_pos_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hc <= LAST);
   // R2: after the last position the next line starts at zero
   p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |=> (hc == '0) && hsync_n);
endmodule

// File: rtl/vga_vert_seq.sv
module vga_vert_seq
   import vga_scan_pkg::*;
#(
   parameter int VIS_START   = 2,
   parameter int VFP_START   = 12,
   parameter int VSYNC_START = 14,
   parameter int VSYNC_END   = 16,
   parameter int LINE_LEN    = 160,
   parameter int SCREEN_SIZE = 640,
   parameter int ADDR_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_end,
   input  logic [ADDR_W-1:0] frame_base,
   output vphase_t           phase,
   output logic [ADDR_W-1:0] row_addr,
   output logic              vsync_n
);
   localparam int LC_W = $clog2(VSYNC_END + 1);
   localparam logic [LC_W-1:0] L_VIS  = LC_W'(VIS_START);
   localparam logic [LC_W-1:0] L_VFP  = LC_W'(VFP_START);
   localparam logic [LC_W-1:0] L_VS   = LC_W'(VSYNC_START);
   localparam logic [LC_W-1:0] L_VEND = LC_W'(VSYNC_END);
   localparam logic [ADDR_W:0] STEP   = (ADDR_W+1)'(LINE_LEN);
   localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(SCREEN_SIZE);

   logic [LC_W-1:0]   cnt, cnt_nx;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W:0]   row_step, row_lim;
   logic              row_fold;

   assign cnt_nx   = cnt + 1'b1;
   assign row_step = {1'b0, row_addr} + STEP;
   assign row_lim  = {1'b0, base_q} + SPAN;
   assign row_fold = (row_step >= row_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= VP_BACK;
         cnt      <= '0;
         row_addr <= '0;
         base_q   <= '0;
         vsync_n  <= 1'b1;
      end else if (line_end) begin
         vsync_n <= (phase != VP_SYNC);
         unique case (phase)
            VP_BACK: begin
               cnt <= cnt_nx;
               if (cnt_nx >= L_VIS) begin
                  phase    <= VP_SHOW;
                  row_addr <= frame_base;
                  base_q   <= frame_base;
               end
            end
            VP_SHOW: begin
               cnt <= cnt_nx;
               if (cnt_nx >= L_VFP) begin
                  phase <= VP_FRONT;
               end else if (!cnt_nx[0]) begin
                  row_addr <= row_fold ? base_q : row_step[ADDR_W-1:0];
               end
            end
            VP_FRONT: begin
               cnt <= cnt_nx;
               if (cnt_nx >= L_VS) phase <= VP_SYNC;
            end
            VP_SYNC: begin
               if (cnt_nx >= L_VEND) begin
                  cnt   <= '0;
                  phase <= VP_BACK;
               end else begin
                  cnt <= cnt_nx;
               end
            end
            default: phase <= VP_BACK;
         endcase
      end
   end

   // R3: phase moves only at a line boundary
   p_phase_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> $past(line_end));
   // R3: phase steps only to its successor
   p_phase_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> (phase == vphase_t'($past(phase) + 2'd1)));
   // R10: vsync edges sit on line boundaries
   p_vsync_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync_n != $past(vsync_n)) |-> $past(line_end));
   // R7: entering an odd visible line keeps the row
   p_row_hold_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(line_end) && $past(phase) == VP_SHOW && phase == VP_SHOW && cnt[0])
      |-> $stable(row_addr));
   // R8: the row never reaches the end of the screen buffer
   p_row_in_screen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == VP_SHOW) |-> ({1'b0, row_addr} < row_lim));
endmodule

// File: rtl/vga_pix_fetch.sv
module vga_pix_fetch #(
   parameter int LINE_LEN = 160,
   parameter int ADDR_W   = 16,
   parameter int PIX_W    = 8,
   parameter int HC_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HC_W-1:0]   hc,
   input  logic              line_end,
   input  logic              show,
   input  logic [ADDR_W-1:0] row_addr,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [PIX_W-1:0]  mem_rdata,
   output logic [PIX_W-1:0]  pix
);
   localparam logic [HC_W-1:0] LEN = HC_W'(LINE_LEN);

   logic            data_live;
   logic [HC_W-1:0] rd_cnt;

   assign mem_rd_en = show && (hc < LEN);
   assign mem_addr  = row_addr + ADDR_W'(hc);
   assign pix       = data_live ? mem_rdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_live <= 1'b0;
      else        data_live <= mem_rd_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_cnt <= '0;
      else if (line_end)  rd_cnt <= '0;
      else if (mem_rd_en) rd_cnt <= rd_cnt + 1'b1;
   end

   // R5: consecutive reads walk the row one byte at a time
   p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en) && !$past(line_end))
      |-> (mem_addr == $past(mem_addr) + 1'b1));
   // R5: a line carries either no burst or a full one
   p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |-> (rd_cnt == '0 || rd_cnt == LEN));
endmodule

// File: rtl/vga_scan_seq.sv
module vga_scan_seq
   import vga_scan_pkg::*;
#(
   parameter int LINE_PERIOD = 200,
   parameter int LINE_LEN    = 160,
   parameter int HS_START    = 168,
   parameter int HS_END      = 184,
   parameter int VIS_START   = 2,
   parameter int VFP_START   = 12,
   parameter int VSYNC_START = 14,
   parameter int VSYNC_END   = 16,
   parameter int SCREEN_SIZE = 640,
   parameter int ADDR_W      = 16,
   parameter int PIX_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] frame_base,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [PIX_W-1:0]  mem_rdata,
   output logic [PIX_W-1:0]  pix,
   output logic              hsync_n,
   output logic              vsync_n
);
   localparam int HC_W = $clog2(LINE_PERIOD);

   initial begin
      a_hs_after_burst: assert (HS_START > LINE_LEN)
         else $error("hsync must start after the last pixel");
      a_hs_order: assert (HS_END > HS_START && HS_END < LINE_PERIOD)
         else $error("hsync window must lie inside the line");
      a_vert_order: assert (VIS_START >= 1 && VIS_START < VFP_START &&
                            VFP_START < VSYNC_START && VSYNC_START < VSYNC_END)
         else $error("vertical phase starts must increase");
      a_screen: assert (SCREEN_SIZE >= LINE_LEN && ADDR_W > HC_W)
         else $error("screen must hold a row and address must cover a line");
   end

   logic [HC_W-1:0]   hc;
   logic              line_end;
   vphase_t           phase;
   logic [ADDR_W-1:0] row_addr;

   vga_line_timer #(
      .LINE_PERIOD(LINE_PERIOD), .HS_START(HS_START),
      .HS_END(HS_END), .HC_W(HC_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .hc(hc), .line_end(line_end), .hsync_n(hsync_n)
   );

   vga_vert_seq #(
      .VIS_START(VIS_START), .VFP_START(VFP_START), .VSYNC_START(VSYNC_START),
      .VSYNC_END(VSYNC_END), .LINE_LEN(LINE_LEN), .SCREEN_SIZE(SCREEN_SIZE),
      .ADDR_W(ADDR_W)
   ) u_vert (
      .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_base(frame_base),
      .phase(phase), .row_addr(row_addr), .vsync_n(vsync_n)
   );

   vga_pix_fetch #(
      .LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W), .PIX_W(PIX_W), .HC_W(HC_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .hc(hc), .line_end(line_end),
      .show(phase == VP_SHOW), .row_addr(row_addr),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .pix(pix)
   );

   // R2 and R9: sync pulse never overlaps reads or active pixels
   p_hsync_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_n |-> (!mem_rd_en && pix == '0));
   // R11: no reads while vertical sync is low
   p_no_burst_in_vsync_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> !mem_rd_en);
endmodule

// File: tb/vga_scan_seq_tb.sv
`timescale 1ns/100ps
module vga_scan_seq_tb;
   localparam int LP   = 200;
   localparam int LEN  = 160;
   localparam int HS_S = 168;
   localparam int HS_E = 184;
   localparam int VIS  = 2;
   localparam int VFP  = 12;
   localparam int VS_S = 14;
   localparam int VS_E = 16;
   localparam int SCR  = 640;
   localparam int FRAME = LP * VS_E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] frame_base = '0;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic [7:0]  pix;
   logic        hsync_n, vsync_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   vga_scan_seq #(
      .LINE_PERIOD(LP), .LINE_LEN(LEN), .HS_START(HS_S), .HS_END(HS_E),
      .VIS_START(VIS), .VFP_START(VFP), .VSYNC_START(VS_S), .VSYNC_END(VS_E),
      .SCREEN_SIZE(SCR), .ADDR_W(16), .PIX_W(8)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_base(frame_base),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .pix(pix), .hsync_n(hsync_n), .vsync_n(vsync_n)
   );

   function automatic logic [7:0] pixf(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // pixel memory with one clock of latency
   always @(posedge clk) if (mem_rd_en) mem_rdata <= pixf(mem_addr);

   // reference model built from the requirements
   int m_hc = 0, m_line = 0, m_row = 0, m_base = 0;
   bit m_vs = 1'b1, m_folded = 1'b0;
   always @(posedge clk) begin
      int nl;
      if (!rst_n) begin
         m_hc = 0; m_line = 0; m_row = 0; m_base = 0; m_vs = 1'b1; m_folded = 1'b0;
      end else if (m_hc == LP - 1) begin
         m_hc = 0;
         m_vs = !(m_line >= VS_S);
         nl = (m_line == VS_E - 1) ? 0 : m_line + 1;
         m_folded = 1'b0;
         if (nl == VIS) begin
            m_base = int'(frame_base);
            m_row  = int'(frame_base);
         end else if (nl > VIS && nl < VFP && (nl % 2) == 0) begin
            m_row = m_row + LEN;
            if (m_row >= m_base + SCR) begin
               m_row = m_base;
               m_folded = 1'b1;
            end
         end
         m_line = nl;
      end else begin
         m_hc++;
      end
   end

   int cyc = 0, last_fall = -1;
   bit prev_vs = 1'b1;
   always @(negedge clk) begin
      bit vis, exp_rd;
      int exp_pix;
      cyc++;
      if (!rst_n) begin
         last_fall = -1;
         prev_vs = 1'b1;
      end else begin
         vis     = (m_line >= VIS) && (m_line < VFP);
         exp_rd  = vis && (m_hc < LEN);
         exp_pix = (vis && m_hc >= 1 && m_hc <= LEN) ? int'(pixf(16'(m_row + m_hc - 1))) : 0;
         if (m_hc == 0)  chk("R3 burst line", int'(mem_rd_en), int'(exp_rd));
         else if (vis)   chk("R5 read strobe", int'(mem_rd_en), int'(exp_rd));
         else            chk("R11 no read", int'(mem_rd_en), 0);
         if (exp_rd) begin
            if (m_line == VIS)  chk("R6 first row addr", int'(mem_addr), m_row + m_hc);
            else if (m_folded)  chk("R8 folded row addr", int'(mem_addr), m_row + m_hc);
            else                chk("R7 row addr", int'(mem_addr), m_row + m_hc);
         end
         if (exp_pix == 0 && !(vis && m_hc >= 1 && m_hc <= LEN))
            chk("R9 blank pix", int'(pix), 0);
         else
            chk("R5 pixel data", int'(pix), exp_pix);
         chk("R2 hsync", int'(hsync_n), int'(!(m_hc >= HS_S && m_hc < HS_E)));
         chk("R10 vsync", int'(vsync_n), int'(m_vs));
         if (prev_vs && !vsync_n) begin
            if (last_fall >= 0) chk("R4 frame period", cyc - last_fall, FRAME);
            last_fall = cyc;
         end
         prev_vs = vsync_n;
      end
   end

   task automatic reset_check();
      chk("R1 hsync_n", int'(hsync_n), 1);
      chk("R1 vsync_n", int'(vsync_n), 1);
      chk("R1 pix", int'(pix), 0);
      chk("R1 mem_rd_en", int'(mem_rd_en), 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fork
         begin
            repeat (4) @(negedge clk);
            reset_check();
            rst_n = 1'b1;
            @(negedge clk);
            reset_check();
            // directed: base zero, two frames
            repeat (2 * FRAME) @(negedge clk);
            // directed: high base, one frame
            frame_base = 16'h7F00;
            repeat (FRAME) @(negedge clk);
            // random base changes at random moments
            repeat (3 * FRAME) begin
               @(negedge clk);
               if ($urandom % 700 == 0) frame_base = 16'($urandom % 30000);
            end
            // reset in the middle of a visible line
            while (!mem_rd_en) @(negedge clk);
            repeat (37) @(negedge clk);
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            reset_check();
            rst_n = 1'b1;
            frame_base = 16'h0123;
            repeat (FRAME + LP) @(negedge clk);
         end
         begin
            repeat (100000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule